// File: doc/BRIEF.md
# SD Card Command Line Engine

This block runs the command half of an SD/MMC host link. On a rising edge of its enable, it captures a 6-bit command index, a 32-bit argument and a 2-bit response code. It then shifts a 48-bit command frame out on the CMD line, one bit per launch strobe of the card clock. Depending on the response code, it either finishes at once or listens for a response from the card. The response is either a 48-bit short reply or a 136-bit long reply, and the block samples it one bit per sample strobe.

When a command finishes, the block latches the response payload into four 32-bit words and raises one sticky status flag. That flag reports whether the command was sent, the response arrived, the CRC was bad, or the card never answered. Software clears the flags by writing ones on a clear port. An active bit stays high while a command is in flight. Dropping the enable during that time abandons the command at once.

Top module: `sdcmd_path`

## Requirements
- R1: A command frame is 48 bits, sent MSB first on successive launch strobes with `cmd_oe` high for exactly those 48 bits: a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument, a 7-bit CRC (polynomial x^7+x^3+1, register starting at zero, computed over the preceding 40 bits), and a 1 end bit. Index 0 with argument 0 therefore gives the frame 0x400000000095.
- R2: With `wait_rsp` = 00, the block listens for no response. After the end bit it raises only the sent flag (`status[7]`) and clears the active bit.
- R3: With `wait_rsp` = 01, a 48-bit response is checked. Its CRC over the first 40 bits must match the 7 bits before the end bit, and the end bit must be 1. On a pass the block raises only the response-end flag (`status[6]`). On a failure it raises only the CRC-fail flag (`status[0]`).
- R4: With `wait_rsp` = 10, a 48-bit response is accepted without any CRC check, and the block raises `status[6]` even when the CRC is wrong.
- R5: With `wait_rsp` = 11, a 136-bit response is taken without a CRC check and the block raises `status[6]`. Counting the 136 received bits from 135 (the first) down to 0, {`rsp1`,`rsp2`,`rsp3`,`rsp4`} becomes {bits 127..1, 1'b0}, so `rsp1` holds the most significant part.
- R6: A short response writes bits 39..8 of the frame (the 32-bit payload) to `rsp1` and leaves `rsp2` to `rsp4` unchanged. A timeout or a command with no response leaves all four words unchanged.
- R7: The response start bit must appear within 64 sample strobes, counted from the sample in the card-clock period where the line is released. If the start bit arrives on the 64th sample, the response is accepted. If all 64 samples read high, the block raises only the timeout flag (`status[2]`).
- R8: Flags are sticky. When `clr_wr` is high, each 1 in `clr_mask` clears the flag at the same bit position. Flags whose mask bit is 0 keep their value.
- R9: The active bit (`status[13]`) is 1 from the clock edge that accepts a start until the command finishes. If `path_en` is low while the command is active, the block goes idle at the next edge with `cmd_oe` low and raises no completion flag.
- R10: A command starts only on a 0-to-1 transition of `path_en` while idle. Holding `path_en` high after completion starts nothing.
- R11: After reset, `status` is 0, all response words are 0, `cmd_oe` is 0 and `cmd_out` is 1. Whenever `cmd_oe` is low, `cmd_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| path_en | input | 1 | Command enable; a rising edge starts a command, and low aborts one |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| wait_rsp | input | 2 | Response code: 00 none, 01 short with CRC check, 10 short without check, 11 long |
| launch_stb | input | 1 | One-cycle pulse at each card-clock launch point |
| sample_stb | input | 1 | One-cycle pulse at each card-clock sample point |
| cmd_in | input | 1 | CMD line as seen from the card |
| cmd_out | output | 1 | CMD line driven value |
| cmd_oe | output | 1 | CMD line output enable |
| rsp1 | output | 32 | Response word 1 (payload of a short response, top bits of a long one) |
| rsp2 | output | 32 | Response word 2 |
| rsp3 | output | 32 | Response word 3 |
| rsp4 | output | 32 | Response word 4 |
| clr_wr | input | 1 | Flag clear strobe |
| clr_mask | input | 14 | Write-one-to-clear mask, aligned with `status` |
| status | output | 14 | Bit 0 CRC fail, bit 2 timeout, bit 6 response end, bit 7 sent, bit 13 active |

## Verification
The embedded properties watch several rules on every cycle:
- The CMD line holds its value between launch strobes and idles high whenever it is not driven.
- No more than one completion flag is raised per command, and a timeout never coincides with a finished response.
- Dropping the enable releases the line at the next edge.
- Cleared flags read zero, and untouched flags hold.
- The lower three response words change only on a long response.

Other behaviour can only be shown by the bench's scenarios: the exact bit order and CRC of the transmitted frame, the mapping of received bits to the response words, and the 63-versus-64 sample timeout boundary. The bench checks these against a card model and its own CRC by polynomial division.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int CMD_LEN       = 48;
  localparam int RSP_SHORT_LEN = 48;
  localparam int RSP_LONG_LEN  = 136;
  localparam int RSP_KEEP      = 128;   // trailing bits kept by the receiver
  localparam int STS_W         = 14;
  localparam int F_CRCBAD      = 0;
  localparam int F_TMO         = 2;
  localparam int F_RSPEND      = 6;
  localparam int F_SENT        = 7;
  localparam int F_ACTIVE      = 13;

  typedef enum logic [1:0] {
    WR_NONE      = 2'b00,
    WR_SHORT_CRC = 2'b01,
    WR_SHORT_RAW = 2'b10,
    WR_LONG      = 2'b11
  } wait_rsp_e;

  typedef enum logic [1:0] {PH_IDLE, PH_TX, PH_RSP} phase_e;

  // Serial CRC7, x^7 + x^3 + 1, MSB first, register starts at zero
  function automatic logic [6:0] crc7_calc(input logic [39:0] d);
    logic [6:0] c;
    logic       fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  function automatic logic [CMD_LEN-1:0] cmd_frame(input logic [5:0] idx,
                                                   input logic [31:0] arg);
    logic [39:0] head;
    head = {2'b01, idx, arg};
    return {head, crc7_calc(head), 1'b1};
  endfunction
endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
  import sdcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        abort,
  input  logic        launch_stb,
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic        tx_done
);
  localparam int CW = $clog2(CMD_LEN + 1);

  logic [CMD_LEN-1:0] sr;
  logic [CW-1:0]      cnt;
  logic               busy;

  wire last_launch = busy && launch_stb && (cnt == CW'(CMD_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      cmd_out <= 1'b1;
      cmd_oe  <= 1'b0;
      tx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (abort) begin
        busy    <= 1'b0;
        cmd_oe  <= 1'b0;
        cmd_out <= 1'b1;
      end else if (load) begin
        sr   <= cmd_frame(idx, arg);
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy && launch_stb) begin
        if (last_launch) begin
          busy    <= 1'b0;
          cmd_oe  <= 1'b0;
          cmd_out <= 1'b1;
          tx_done <= 1'b1;
        end else begin
          cmd_out <= sr[CMD_LEN-1];
          cmd_oe  <= 1'b1;
          sr      <= {sr[CMD_LEN-2:0], 1'b0};
          cnt     <= cnt + CW'(1);
        end
      end
    end
  end

  // R1
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch_stb && !abort) |=> ($stable(cmd_out) && $stable(cmd_oe)));

  // R11
  line_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_oe |-> cmd_out);
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
  import sdcmd_pkg::*;
#(
  parameter int TMO_CYC = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm,
  input  logic                long_mode,
  input  logic                abort,
  input  logic                sample_stb,
  input  logic                cmd_in,
  output logic                rx_done,
  output logic                rx_tmo,
  output logic [RSP_KEEP-1:0] rx_frame
);
  localparam int TW = $clog2(TMO_CYC);
  localparam int LW = $clog2(RSP_LONG_LEN + 1);

  logic          listen, capture;
  logic [TW-1:0] tcnt;
  logic [LW-1:0] bcnt;
  logic [LW-1:0] need;

  assign need = long_mode ? LW'(RSP_LONG_LEN) : LW'(RSP_SHORT_LEN);

  wire start_seen = listen && sample_stb && !cmd_in;
  wire expire     = listen && sample_stb && cmd_in && (tcnt == TW'(TMO_CYC - 1));
  wire last_bit   = capture && sample_stb && (bcnt == need - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      listen   <= 1'b0;
      capture  <= 1'b0;
      tcnt     <= '0;
      bcnt     <= '0;
      rx_frame <= '0;
      rx_done  <= 1'b0;
      rx_tmo   <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      rx_tmo  <= 1'b0;
      if (abort) begin
        listen  <= 1'b0;
        capture <= 1'b0;
      end else if (arm) begin
        listen  <= 1'b1;
        capture <= 1'b0;
        tcnt    <= '0;
      end else if (start_seen) begin
        listen   <= 1'b0;
        capture  <= 1'b1;
        bcnt     <= LW'(1);
        rx_frame <= {rx_frame[RSP_KEEP-2:0], 1'b0};
      end else if (expire) begin
        listen <= 1'b0;
        rx_tmo <= 1'b1;
      end else if (listen && sample_stb) begin
        tcnt <= tcnt + TW'(1);
      end else if (capture && sample_stb) begin
        rx_frame <= {rx_frame[RSP_KEEP-2:0], cmd_in};
        bcnt     <= bcnt + LW'(1);
        if (last_bit) begin
          capture <= 1'b0;
          rx_done <= 1'b1;
        end
      end
    end
  end

  // R7
  tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && rx_tmo));

  // R7
  tmo_on_high_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_tmo) |-> $past(sample_stb && cmd_in));
endmodule

// File: rtl/sdcmd_flags.sv
module sdcmd_flags
  import sdcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] set_vec,
  input  logic             clr_wr,
  input  logic [STS_W-1:0] clr_mask,
  output logic [STS_W-1:0] flags
);
  wire [STS_W-1:0] clr_eff = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_eff) | set_vec;
  end

  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ((clr_mask & set_vec) == '0)) |=> ((flags & $past(clr_mask)) == '0));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && (set_vec == '0)) |=> $stable(flags));
endmodule

// File: rtl/sdcmd_path.sv
module sdcmd_path
  import sdcmd_pkg::*;
#(
  parameter int TMO_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             path_en,
  input  logic [5:0]       cmd_idx,
  input  logic [31:0]      cmd_arg,
  input  logic [1:0]       wait_rsp,
  input  logic             launch_stb,
  input  logic             sample_stb,
  input  logic             cmd_in,
  output logic             cmd_out,
  output logic             cmd_oe,
  output logic [31:0]      rsp1,
  output logic [31:0]      rsp2,
  output logic [31:0]      rsp3,
  output logic [31:0]      rsp4,
  input  logic             clr_wr,
  input  logic [STS_W-1:0] clr_mask,
  output logic [STS_W-1:0] status
);
  phase_e              phase;
  wait_rsp_e           wr_q;
  logic                en_q;
  logic                tx_done, rx_done, rx_tmo;
  logic [RSP_KEEP-1:0] rx_frame;
  logic [STS_W-1:0]    set_vec, flags;

  wire busy      = (phase != PH_IDLE);
  wire start_cmd = path_en && !en_q && !busy;
  wire abort_cmd = busy && !path_en;
  wire tx_fin    = (phase == PH_TX) && tx_done && !abort_cmd;
  wire arm_rx    = tx_fin && (wr_q != WR_NONE);
  wire sent_evt  = tx_fin && (wr_q == WR_NONE);
  wire rsp_live  = (phase == PH_RSP) && !abort_cmd;
  wire crc_ok    = (crc7_calc(rx_frame[47:8]) == rx_frame[7:1]) && rx_frame[0];
  wire bad_evt   = rsp_live && rx_done && (wr_q == WR_SHORT_CRC) && !crc_ok;
  wire end_evt   = rsp_live && rx_done && !bad_evt;
  wire tmo_evt   = rsp_live && rx_tmo;

  sdcmd_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(start_cmd), .abort(abort_cmd),
    .launch_stb(launch_stb), .idx(cmd_idx), .arg(cmd_arg),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .tx_done(tx_done)
  );

  sdcmd_rx #(.TMO_CYC(TMO_CYC)) u_rx (
    .clk(clk), .rst_n(rst_n), .arm(arm_rx), .long_mode(wr_q == WR_LONG),
    .abort(abort_cmd), .sample_stb(sample_stb), .cmd_in(cmd_in),
    .rx_done(rx_done), .rx_tmo(rx_tmo), .rx_frame(rx_frame)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[F_CRCBAD] = bad_evt;
    set_vec[F_TMO]    = tmo_evt;
    set_vec[F_RSPEND] = end_evt;
    set_vec[F_SENT]   = sent_evt;
  end

  sdcmd_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .flags(flags)
  );

  always_comb begin
    status           = flags;
    status[F_ACTIVE] = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      wr_q  <= WR_NONE;
      en_q  <= 1'b0;
    end else begin
      en_q <= path_en;
      if (start_cmd) begin
        phase <= PH_TX;
        wr_q  <= wait_rsp_e'(wait_rsp);
      end else if (abort_cmd || sent_evt) begin
        phase <= PH_IDLE;
      end else if (arm_rx) begin
        phase <= PH_RSP;
      end else if (rsp_live && (rx_done || rx_tmo)) begin
        phase <= PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {rsp1, rsp2, rsp3, rsp4} <= '0;
    end else if (rsp_live && rx_done) begin
      if (wr_q == WR_LONG) {rsp1, rsp2, rsp3, rsp4} <= {rx_frame[RSP_KEEP-1:1], 1'b0};
      else                 rsp1 <= rx_frame[39:8];
    end
  end

  // R2
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));

  // R9
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_cmd |=> (!cmd_oe && !status[F_ACTIVE]));

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && en_q && path_en) |=> !status[F_ACTIVE]);

  // R6
  low_words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_live && rx_done && (wr_q == WR_LONG)) |=> $stable({rsp2, rsp3, rsp4}));
endmodule

// File: tb/test_sdcmd_path.sv
module test_sdcmd_path;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 64;

  logic        clk = 1'b0, rst_n = 1'b0, path_en = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [1:0]  wait_rsp = '0;
  logic        launch_stb = 1'b0, sample_stb = 1'b0, cmd_in = 1'b1;
  logic        clr_wr = 1'b0;
  logic [13:0] clr_mask = '0;
  wire         cmd_out, cmd_oe;
  wire [31:0]  rsp1, rsp2, rsp3, rsp4;
  wire [13:0]  status;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_w [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdcmd_path i_sdcmd_path (
    .clk(clk), .rst_n(rst_n), .path_en(path_en), .cmd_idx(cmd_idx),
    .cmd_arg(cmd_arg), .wait_rsp(wait_rsp), .launch_stb(launch_stb),
    .sample_stb(sample_stb), .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .rsp1(rsp1), .rsp2(rsp2), .rsp3(rsp3), .rsp4(rsp4),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .status(status)
  );

  task automatic check(input string req, input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // CRC7 by long division with 0x89 (x^7+x^3+1)
  function automatic logic [6:0] b_crc(input logic [39:0] d);
    logic [46:0] r;
    r = {d, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  task automatic tick(input logic din, output logic dout, output logic doe);
    @(negedge clk); launch_stb = 1'b1;
    @(negedge clk); launch_stb = 1'b0; cmd_in = din; dout = cmd_out; doe = cmd_oe;
    @(negedge clk); sample_stb = 1'b1;
    @(negedge clk); sample_stb = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr_wr = 1'b1; clr_mask = '1;
    @(negedge clk); clr_wr = 1'b0; clr_mask = '0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!status[13]) break;
    end
  endtask

  // Starts a command and returns after the frame is sent and the line released
  task automatic send_frame(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] wr);
    logic [47:0] host, exp;
    logic o, e;
    int nb;
    host = '0; nb = 0;
    cmd_idx = idx; cmd_arg = arg; wait_rsp = wr; path_en = 1'b1;
    @(negedge clk);
    check("R9 active after enable rise", status[13], 1'b1);
    for (int k = 0; k < 60; k++) begin
      tick(1'b1, o, e);
      if (e) begin host = {host[46:0], o}; nb++; end
      else if (nb > 0) break;
    end
    exp = {2'b01, idx, arg, b_crc({2'b01, idx, arg}), 1'b1};
    check("R1 driven bit count", nb, 48);
    check("R1 frame bits", host, exp);
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] wr,
                         input int hi_cnt, input logic bad_crc);
    logic o, e;
    logic [135:0] rsp;
    logic [126:0] body;
    logic [39:0] head;
    logic [6:0] c;
    logic [31:0] pay;
    int rlen;
    logic [13:0] exp_sts;
    clear_all();
    send_frame(idx, arg, wr);
    rsp = '0; rlen = 0; exp_sts = '0;
    if (wr == 2'b00) begin
      wait_idle();
      exp_sts[7] = 1'b1;
      check("R2 sent flag only", status, exp_sts);
    end else if (hi_cnt >= TMO) begin
      for (int k = 0; k < 80 && status[13]; k++) tick(1'b1, o, e);
      wait_idle();
      exp_sts[2] = 1'b1;
      check("R7 timeout flag only", status, exp_sts);
    end else begin
      for (int k = 1; k < hi_cnt; k++) tick(1'b1, o, e);
      if (wr == 2'b11) begin
        body = {$urandom, $urandom, $urandom, $urandom};
        rsp = {2'b00, 6'h3f, body, 1'b1};
        rlen = 136;
        {exp_w[0], exp_w[1], exp_w[2], exp_w[3]} = {body, 1'b0};
      end else begin
        pay = $urandom;
        head = {2'b00, idx, pay};
        c = b_crc(head) ^ {6'b0, bad_crc};
        rsp[47:0] = {head, c, 1'b1};
        rlen = 48;
        exp_w[0] = pay;
      end
      for (int b = rlen - 1; b >= 0; b--) tick(rsp[b], o, e);
      cmd_in = 1'b1;
      wait_idle();
      if (wr == 2'b01 && bad_crc) exp_sts[0] = 1'b1;
      else                        exp_sts[6] = 1'b1;
      if (wr == 2'b01) check("R3 crc-checked short result", status, exp_sts);
      else if (wr == 2'b10) check("R4 unchecked short result", status, exp_sts);
      else check("R5 long result", status, exp_sts);
    end
    check("R5 R6 response words", {rsp1, rsp2, rsp3, rsp4},
          {exp_w[0], exp_w[1], exp_w[2], exp_w[3]});
    // R10: enable still high, no new command
    for (int k = 0; k < 6; k++) @(negedge clk);
    check("R10 no restart while held", status[13], 1'b0);
    check("R11 line released high", {cmd_oe, cmd_out}, 2'b01);
    path_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic o, e;
    logic [13:0] exp_sts;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) exp_w[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset status", status, 14'h0);
    check("R11 reset words", {rsp1, rsp2, rsp3, rsp4}, 128'h0);
    check("R11 reset line", {cmd_oe, cmd_out}, 2'b01);

    // R1: known frame for index 0, argument 0
    clear_all();
    send_frame(6'd0, 32'd0, 2'b00);
    wait_idle();
    check("R2 sent after plain command", status, 14'h0080);
    path_en = 1'b0; @(negedge clk);

    // R8: selective clear, sticky hold
    repeat (10) @(negedge clk);
    check("R8 flag sticky", status, 14'h0080);
    @(negedge clk); clr_wr = 1'b1; clr_mask = 14'h0004;
    @(negedge clk); clr_wr = 1'b0; clr_mask = '0;
    check("R8 unmasked flag kept", status, 14'h0080);
    @(negedge clk); clr_wr = 1'b1; clr_mask = 14'h0080;
    @(negedge clk); clr_wr = 1'b0; clr_mask = '0;
    check("R8 masked flag cleared", status, 14'h0000);

    // Directed corner cases
    run_cmd(6'd2, 32'h0, 2'b11, 3, 1'b0);          // R5 long
    run_cmd(6'd13, 32'hA5A5_0001, 2'b01, 2, 1'b0); // R6 words 2-4 kept
    run_cmd(6'd17, 32'h0000_0200, 2'b01, 1, 1'b1); // R3 bad crc
    run_cmd(6'd55, 32'h1234_5678, 2'b10, 5, 1'b1); // R4 bad crc ignored
    run_cmd(6'd8, 32'h0000_01AA, 2'b01, TMO - 1, 1'b0); // R7 last chance
    run_cmd(6'd8, 32'h0000_01AA, 2'b01, TMO, 1'b0);     // R7 timeout, R6 words kept
    run_cmd(6'd9, 32'hFFFF_FFFF, 2'b11, TMO, 1'b0);     // R7 long timeout

    // R9: abort during frame
    clear_all();
    cmd_idx = 6'd24; cmd_arg = 32'hDEAD_BEEF; wait_rsp = 2'b01; path_en = 1'b1;
    for (int k = 0; k < 10; k++) tick(1'b1, o, e);
    check("R9 driving before abort", cmd_oe, 1'b1);
    path_en = 1'b0;
    @(negedge clk);
    check("R9 abort in frame idle", status, 14'h0000);
    check("R9 abort releases line", {cmd_oe, cmd_out}, 2'b01);

    // R9: abort while waiting for a response
    clear_all();
    send_frame(6'd7, 32'h0000_0042, 2'b10);
    tick(1'b1, o, e); tick(1'b1, o, e);
    path_en = 1'b0;
    @(negedge clk);
    check("R9 abort in wait idle", status, 14'h0000);
    for (int k = 0; k < 70; k++) tick(1'b1, o, e);
    check("R9 no timeout after abort", status, 14'h0000);
    check("R9 words kept after abort", {rsp1, rsp2, rsp3, rsp4},
          {exp_w[0], exp_w[1], exp_w[2], exp_w[3]});

    // Random mix
    for (int n = 0; n < 16; n++) begin
      logic [1:0] wr;
      int hi;
      wr = 2'($urandom % 4);
      hi = 1 + int'($urandom % 20);
      run_cmd(6'($urandom), $urandom, wr, hi, 1'($urandom % 2));
    end

    exp_sts = '0;
    check("R8 flags after last idle", status & 14'h2000, exp_sts);
    summary();
  end
endmodule